// File: doc/BRIEF.md
# Erase-Block Write-Protection Range Manager

This block keeps one write-protection state for each erase block of a flash array and changes those states on command. Software first loads a first-block and a last-block register to pick a span of blocks, then issues one of four operations: open (unlock) the span, lock the span, freeze the span in a sticky lock-tight state, or open every block in the array. The block then steps through the blocks one per clock and updates each one it reaches. While it does this it holds a busy output high.

Lock-tight is the only state that stops the other operations. An unlock or lock walk, including the whole-array open, ends at the first frozen block it meets. Only a cold reset returns a frozen block to locked. The freeze walk leaves open blocks alone and moves past them. A status output holds the state most recently written to any block. An error flag records a walk that ran beyond the last block that exists. A completion flag marks the end of every operation.

Top module: `wp_range_mgr`

## Requirements
- R1: On cold reset (rstN low) every block reads locked, wpStatus reads 3'b010, and busy, intFlag and cmdErr read 0. Block states are one-hot: 3'b001 lock-tight, 3'b010 locked, 3'b100 unlocked. Block b sits at blkState[3b+2:3b].
- R2: A write to the first-block register (startWr) loads both startAddr and endAddr. A write to the last-block register (endWr) loads only endAddr. Each keeps only the low IDX_W bits of addrIn, where IDX_W = clog2(NUM_BLOCKS).
- R3: A command is accepted on cmdValid when the block is idle. Codes are 0 unlock, 1 lock, 2 lock-tight and 3 unlock-all. Range commands visit startAddr through endAddr inclusive, one block per clock, and busy stays high one cycle per visited block. If startAddr > endAddr, the command changes no block and busy is high for one cycle.
- R4: Unlock, lock and unlock-all end at the first lock-tight block they reach. That block and every later block in the range keep their states, and a lock-tight block never changes state except by cold reset.
- R5: Lock-tight passes over unlocked blocks without changing them and turns every other visited block into lock-tight.
- R6: Unlock-all visits block 0 through block NUM_BLOCKS-1 and ignores the address registers.
- R7: When a walk reaches a block index at or above NUM_BLOCKS, cmdErr is set and the walk ends. Blocks visited before that point keep their updates.
- R8: Each block update copies the new state into wpStatus. A command that writes no block leaves wpStatus unchanged.
- R9: Every command sets intFlag when its walk ends. intClr clears both intFlag and cmdErr.
- R10: A cmdValid pulse while busy is high is ignored.
- R11: A warm reset (warmRst high) returns the address registers, wpStatus, the flags and the walker to their reset values and leaves every block state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low cold reset |
| warmRst | input | 1 | Synchronous warm reset; block states kept |
| startWr | input | 1 | Write strobe for the first-block register |
| endWr | input | 1 | Write strobe for the last-block register |
| addrIn | input | ADDR_W | Address write data |
| cmdValid | input | 1 | Command issue strobe |
| cmdOp | input | 2 | Command code |
| intClr | input | 1 | Clears intFlag and cmdErr |
| busy | output | 1 | Walk in progress |
| cmdErr | output | 1 | Walk ran past the last block |
| intFlag | output | 1 | Command completed |
| wpStatus | output | 3 | Last state written to a block |
| startAddr | output | IDX_W | First-block register |
| endAddr | output | IDX_W | Last-block register |
| blkState | output | 3*NUM_BLOCKS | All block states, three bits per block |

## Verification
The assertions run on every cycle. They check that each block state stays one-hot, that a lock-tight block never leaves that state, that the walker cursor advances by exactly one on each busy cycle, that every block write shows up in wpStatus on the next cycle, and that the error flag never rises without the completion flag. The scenarios cover the rest, which depends on the order of commands: where a walk stops at a frozen block, how the freeze walk passes over open blocks, empty and out-of-range spans, address masking, commands that arrive while busy is high, and the different results of warm and cold reset on the block array.

// File: rtl/prot_pkg.sv
package prot_pkg;

  typedef enum logic [2:0] {
    PS_TIGHT  = 3'b001,
    PS_LOCKED = 3'b010,
    PS_OPEN   = 3'b100
  } protState_e;

  typedef enum logic [1:0] {
    OP_UNLOCK   = 2'd0,
    OP_LOCK     = 2'd1,
    OP_TIGHT    = 2'd2,
    OP_OPEN_ALL = 2'd3
  } protOp_e;

  typedef struct packed {
    logic       wrEn;
    logic       setErr;
    logic       setInt;
    protState_e wrVal;
  } protStrobe_t;

endpackage

// File: rtl/prot_ctl.sv
module prot_ctl
  import prot_pkg::*;
#(
  parameter int NUM_BLOCKS = 12,
  parameter int IDX_W      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              warmRst,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [IDX_W-1:0]  startAddr,
  input  logic [IDX_W-1:0]  endAddr,
  input  protState_e        curState,
  output logic              busy,
  output logic [IDX_W-1:0]  cursor,
  output protStrobe_t       strobe
);

  localparam logic [IDX_W:0]   LIMIT   = (IDX_W+1)'(NUM_BLOCKS);
  localparam logic [IDX_W-1:0] LAST_BLK = IDX_W'(NUM_BLOCKS - 1);

  logic              walking;
  protOp_e           opReg;
  logic [IDX_W-1:0]  lastIdx;
  logic              done;
  protStrobe_t       stbRaw;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      walking <= 1'b0;
      opReg   <= OP_UNLOCK;
      cursor  <= '0;
      lastIdx <= '0;
    end else if (warmRst) begin
      walking <= 1'b0;
      opReg   <= OP_UNLOCK;
      cursor  <= '0;
      lastIdx <= '0;
    end else if (!walking) begin
      if (cmdValid) begin
        walking <= 1'b1;
        opReg   <= protOp_e'(cmdOp);
        if (protOp_e'(cmdOp) == OP_OPEN_ALL) begin
          cursor  <= '0;
          lastIdx <= LAST_BLK;
        end else begin
          cursor  <= startAddr;
          lastIdx <= endAddr;
        end
      end
    end else if (done) begin
      walking <= 1'b0;
    end else begin
      cursor <= cursor + 1'b1;
    end
  end

  // One decision per visited block
  always_comb begin
    stbRaw = '{wrEn: 1'b0, setErr: 1'b0, setInt: 1'b0, wrVal: PS_LOCKED};
    done   = 1'b0;
    if (cursor > lastIdx) begin
      done = 1'b1;
    end else if ({1'b0, cursor} >= LIMIT) begin
      done          = 1'b1;
      stbRaw.setErr = 1'b1;
    end else if (opReg == OP_TIGHT) begin
      if (curState != PS_OPEN) begin
        stbRaw.wrEn  = 1'b1;
        stbRaw.wrVal = PS_TIGHT;
      end
      done = (cursor == lastIdx);
    end else if (curState == PS_TIGHT) begin
      done = 1'b1;
    end else begin
      stbRaw.wrEn  = 1'b1;
      stbRaw.wrVal = (opReg == OP_LOCK) ? PS_LOCKED : PS_OPEN;
      done = (cursor == lastIdx);
    end
    stbRaw.setInt = done;
  end

  assign busy   = walking;
  assign strobe = (walking && !warmRst) ? stbRaw
                : '{wrEn: 1'b0, setErr: 1'b0, setInt: 1'b0, wrVal: PS_LOCKED};

  AST_CURSOR_STEP: assert property (@(posedge clk) disable iff (!rstN || warmRst)
    (busy && $past(busy)) |-> (cursor == $past(cursor) + 1'b1)); // R3

endmodule

// File: rtl/prot_dp.sv
module prot_dp
  import prot_pkg::*;
#(
  parameter int NUM_BLOCKS = 12,
  parameter int IDX_W      = 4,
  parameter int ADDR_W     = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    warmRst,
  input  logic                    startWr,
  input  logic                    endWr,
  input  logic [ADDR_W-1:0]       addrIn,
  input  logic                    intClr,
  input  protStrobe_t             strobe,
  input  logic [IDX_W-1:0]        cursor,
  output logic [IDX_W-1:0]        startAddr,
  output logic [IDX_W-1:0]        endAddr,
  output protState_e              curState,
  output protState_e              wpStatus,
  output logic                    cmdErr,
  output logic                    intFlag,
  output logic [3*NUM_BLOCKS-1:0] blkState
);

  protState_e stArr [NUM_BLOCKS];

  for (genvar g = 0; g < NUM_BLOCKS; g++) begin : gBlk
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        stArr[g] <= PS_LOCKED;
      else if (strobe.wrEn && cursor == IDX_W'(g))
        stArr[g] <= strobe.wrVal;
    end
    assign blkState[3*g +: 3] = stArr[g];

    AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
      $onehot(stArr[g])); // R1
    AST_TIGHT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      ($past(stArr[g]) == PS_TIGHT) |-> (stArr[g] == PS_TIGHT)); // R4
  end

  always_comb begin
    curState = PS_LOCKED;
    for (int i = 0; i < NUM_BLOCKS; i++)
      if (cursor == IDX_W'(i)) curState = stArr[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startAddr <= '0;
      endAddr   <= '0;
      wpStatus  <= PS_LOCKED;
      cmdErr    <= 1'b0;
      intFlag   <= 1'b0;
    end else if (warmRst) begin
      startAddr <= '0;
      endAddr   <= '0;
      wpStatus  <= PS_LOCKED;
      cmdErr    <= 1'b0;
      intFlag   <= 1'b0;
    end else begin
      if (startWr) begin
        startAddr <= addrIn[IDX_W-1:0];
        endAddr   <= addrIn[IDX_W-1:0];
      end else if (endWr) begin
        endAddr <= addrIn[IDX_W-1:0];
      end
      if (strobe.wrEn) wpStatus <= strobe.wrVal;
      if (strobe.setErr)  cmdErr <= 1'b1;
      else if (intClr)    cmdErr <= 1'b0;
      if (strobe.setInt)  intFlag <= 1'b1;
      else if (intClr)    intFlag <= 1'b0;
    end
  end

  AST_WR_TO_STATUS: assert property (@(posedge clk) disable iff (!rstN || warmRst)
    strobe.wrEn |=> (wpStatus == $past(strobe.wrVal))); // R8
  AST_ERR_WITH_INT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmdErr) |-> intFlag); // R7
  AST_STATUS_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(wpStatus)); // R8

endmodule

// File: rtl/wp_range_mgr.sv
module wp_range_mgr
  import prot_pkg::*;
#(
  parameter  int NUM_BLOCKS = 12,
  parameter  int ADDR_W     = 16,
  localparam int IDX_W      = $clog2(NUM_BLOCKS)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    warmRst,
  input  logic                    startWr,
  input  logic                    endWr,
  input  logic [ADDR_W-1:0]       addrIn,
  input  logic                    cmdValid,
  input  logic [1:0]              cmdOp,
  input  logic                    intClr,
  output logic                    busy,
  output logic                    cmdErr,
  output logic                    intFlag,
  output logic [2:0]              wpStatus,
  output logic [IDX_W-1:0]        startAddr,
  output logic [IDX_W-1:0]        endAddr,
  output logic [3*NUM_BLOCKS-1:0] blkState
);

  protStrobe_t      strobe;
  logic [IDX_W-1:0] cursor;
  protState_e       curState;
  protState_e       wpState;

  prot_ctl #(.NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W)) uCtl (
    .clk(clk), .rstN(rstN), .warmRst(warmRst),
    .cmdValid(cmdValid), .cmdOp(cmdOp),
    .startAddr(startAddr), .endAddr(endAddr), .curState(curState),
    .busy(busy), .cursor(cursor), .strobe(strobe)
  );

  prot_dp #(.NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rstN(rstN), .warmRst(warmRst),
    .startWr(startWr), .endWr(endWr), .addrIn(addrIn), .intClr(intClr),
    .strobe(strobe), .cursor(cursor),
    .startAddr(startAddr), .endAddr(endAddr), .curState(curState),
    .wpStatus(wpState), .cmdErr(cmdErr), .intFlag(intFlag),
    .blkState(blkState)
  );

  assign wpStatus = wpState;

endmodule

// File: tb/sim_wp_range_mgr.sv
`timescale 1ns/1ps
module sim_wp_range_mgr;

  localparam int NB = 12;

  logic clk = 1'b0, rstN = 1'b0, warmRst = 1'b0;
  logic startWr = 1'b0, endWr = 1'b0, cmdValid = 1'b0, intClr = 1'b0;
  logic [15:0] addrIn = '0;
  logic [1:0]  cmdOp = '0;
  logic busy, cmdErr, intFlag;
  logic [2:0] wpStatus;
  logic [3:0] startAddr, endAddr;
  logic [3*NB-1:0] blkState;

  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  wp_range_mgr #(.NUM_BLOCKS(NB), .ADDR_W(16)) u0 (
    .clk(clk), .rstN(rstN), .warmRst(warmRst), .startWr(startWr), .endWr(endWr),
    .addrIn(addrIn), .cmdValid(cmdValid), .cmdOp(cmdOp), .intClr(intClr),
    .busy(busy), .cmdErr(cmdErr), .intFlag(intFlag), .wpStatus(wpStatus),
    .startAddr(startAddr), .endAddr(endAddr), .blkState(blkState)
  );

  typedef struct packed {
    logic [15:0] startV;
    logic [15:0] endV;
    logic        setEnd;
    logic [1:0]  op;
    logic [95:0] expMap;   // leftmost char = block 0
    logic [2:0]  expWp;
    logic        expErr;
    logic [4:0]  expCyc;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{16'd2,  16'd5,  1'b1, 2'd0, "LLUUUULLLLLL", 3'd4, 1'b0, 5'd4},  // R3 unlock range
    '{16'd3,  16'd0,  1'b0, 2'd1, "LLULUULLLLLL", 3'd2, 1'b0, 5'd1},  // R2 end copied
    '{16'd0,  16'd6,  1'b1, 2'd2, "TTUTUUTLLLLL", 3'd1, 1'b0, 5'd7},  // R5 skip open
    '{16'd4,  16'd9,  1'b1, 2'd1, "TTUTLLTLLLLL", 3'd2, 1'b0, 5'd3},  // R4 stop at tight
    '{16'd0,  16'd0,  1'b0, 2'd3, "TTUTLLTLLLLL", 3'd2, 1'b0, 5'd1},  // R6 R8 stop at 0
    '{16'd7,  16'd13, 1'b1, 2'd0, "TTUTLLTUUUUU", 3'd4, 1'b1, 5'd6},  // R7 past end
    '{16'd9,  16'd8,  1'b1, 2'd1, "TTUTLLTUUUUU", 3'd4, 1'b0, 5'd1},  // R3 empty
    '{16'hFF8,16'h1009,1'b1,2'd1, "TTUTLLTULLUU", 3'd2, 1'b0, 5'd2}   // R2 masking
  };

  function automatic logic [2:0] chr2st(logic [7:0] c);
    case (c)
      "T": return 3'b001;
      "L": return 3'b010;
      "U": return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  function automatic logic [3*NB-1:0] mapOf(logic [95:0] m);
    logic [3*NB-1:0] r;
    for (int b = 0; b < NB; b++) r[3*b +: 3] = chr2st(m[8*(NB-1-b) +: 8]);
    return r;
  endfunction

  function automatic logic [3*NB-1:0] allOf(logic [2:0] s);
    logic [3*NB-1:0] r;
    for (int b = 0; b < NB; b++) r[3*b +: 3] = s;
    return r;
  endfunction

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic wrStart(logic [15:0] v);
    @(negedge clk); startWr = 1'b1; addrIn = v;
    @(negedge clk); startWr = 1'b0;
  endtask

  task automatic wrEnd(logic [15:0] v);
    @(negedge clk); endWr = 1'b1; addrIn = v;
    @(negedge clk); endWr = 1'b0;
  endtask

  task automatic clearInt();
    @(negedge clk); intClr = 1'b1;
    @(negedge clk); intClr = 1'b0;
  endtask

  // poke: re-issue a lock command on the first busy cycle
  task automatic runCmd(logic [1:0] op, bit poke, output int cyc);
    @(negedge clk); cmdValid = 1'b1; cmdOp = op;
    @(negedge clk); cmdValid = 1'b0;
    cyc = 0;
    while (busy && cyc < 100) begin
      cyc++;
      if (poke && cyc == 1) begin cmdValid = 1'b1; cmdOp = 2'd1; end
      else cmdValid = 1'b0;
      @(negedge clk);
    end
    cmdValid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL R3 watchdog expired got=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    // R1 cold reset state
    chk("R1 map", blkState, allOf(3'b010));
    chk("R1 wp", wpStatus, 3'b010);
    chk("R1 flags", {busy, intFlag, cmdErr}, 3'b000);
    rstN = 1'b1;
    @(negedge clk);

    // R2 masking and start-copies-end
    wrStart(16'h00F5);
    chk("R2 start", startAddr, 4'd5);
    chk("R2 end copy", endAddr, 4'd5);
    wrEnd(16'h0037);
    chk("R2 end only", {startAddr, endAddr}, {4'd5, 4'd7});

    for (int i = 0; i < 8; i++) begin
      wrStart(VEC[i].startV);
      if (VEC[i].setEnd) wrEnd(VEC[i].endV);
      runCmd(VEC[i].op, 1'b0, cyc);
      chk("R3 R4 R5 R6 R7 map", blkState, mapOf(VEC[i].expMap));
      chk("R8 wp", wpStatus, VEC[i].expWp);
      chk("R7 err", cmdErr, VEC[i].expErr);
      chk("R3 cycles", cyc, VEC[i].expCyc);
      chk("R9 int set", intFlag, 1'b1);
      clearInt();
      chk("R9 int clear", {intFlag, cmdErr}, 2'b00);
    end

    // R11 warm reset keeps blocks
    @(negedge clk); warmRst = 1'b1;
    @(negedge clk); warmRst = 1'b0;
    chk("R11 map kept", blkState, mapOf("TTUTLLTULLUU"));
    chk("R11 addr", {startAddr, endAddr}, 8'h00);
    chk("R11 wp", wpStatus, 3'b010);

    // R1 cold reset clears lock-tight
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    chk("R1 tight cleared", blkState, allOf(3'b010));
    rstN = 1'b1;

    // R6 unlock-all with a R10 command pushed while busy
    wrStart(16'd0);
    runCmd(2'd3, 1'b1, cyc);
    chk("R6 all open", blkState, allOf(3'b100));
    chk("R6 cycles", cyc, NB);
    chk("R10 ignored", wpStatus, 3'b100);
    chk("R10 idle", busy, 1'b0);
    clearInt();

    // R5 lock-tight over all-open range writes nothing
    wrStart(16'd0); wrEnd(16'd11);
    runCmd(2'd2, 1'b0, cyc);
    chk("R5 all skipped", blkState, allOf(3'b100));
    chk("R5 cycles", cyc, NB);
    chk("R8 wp unchanged", wpStatus, 3'b100);
    chk("R9 int", intFlag, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule